// File: doc/BRIEF.md
# Template Hot/Cold Deviation Accumulator

This block scores one candidate pixel against one template pair. It receives a stream of 5-bit samples. The first thirty are background samples and the next thirty are target samples. From them it builds four totals: target hot, target cold, background hot and background cold. A sample counts as "hot" when thirty times its value exceeds the plain sum of the background samples. It counts as "cold" otherwise, and the amount added is the magnitude of that difference. Using the scaled sample against the raw sum means no mean, and so no divider, is ever computed.

Background samples are added into a running sum and written into a small buffer as they arrive. Once the thirtieth one is in, the sum is final. Two jobs then run side by side on separate datapaths. The buffer is replayed to score the background samples, and incoming target samples are scored as they arrive. A one-cycle done strobe marks the point where all four totals are final. A start pulse clears the block for the next candidate. Address generation, memory access and the final correlation decision belong to neighbouring logic.

Top module: `hotcold_dev_accum`

## Requirements
- R1: After reset, all four totals read zero, done is low, and the block accepts a new background sample stream without a start pulse.
- R2: A start pulse clears the four totals, the background sum and all sample counts. Done is low in the cycle after start, even when start arrives in the middle of a frame.
- R3: The first 30 accepted background samples (kind input 0) are summed into SUM. Each of them then adds 30·x − SUM to the background hot total when 30·x > SUM, and adds SUM − 30·x to the background cold total otherwise.
- R4: Each of the first 30 accepted target samples (kind input 1) is scored against the same SUM with the same rule, into the target hot and target cold totals.
- R5: When 30·x equals SUM, the sample adds zero and changes neither total.
- R6: A target sample that arrives before all 30 background samples have been accepted is discarded and does not count toward the 30 targets.
- R7: Background samples after the 30th and target samples after the 30th are discarded. They leave the totals unchanged and produce no second done.
- R8: Done is high for exactly one cycle. With 60 back-to-back samples starting the cycle after start, it rises in the second cycle after the cycle that carries the last target sample. The totals hold their values while done is high.
- R9: A sample with valid low is ignored, whatever its data and kind.
- R10: When start and a valid sample occur in the same cycle, start wins and the sample is discarded.
- R11: No total overflows. With all background samples at 31 and all target samples at 0, the target cold total reaches its maximum of 27900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears the block for a new candidate pixel |
| smp_valid_i | input | 1 | A sample is present this cycle |
| smp_is_tgt_i | input | 1 | Sample kind: 0 background, 1 target |
| smp_i | input | 5 | Sample value |
| tgt_hot_o | output | 15 | Target hot total |
| tgt_cold_o | output | 15 | Target cold total |
| bkg_hot_o | output | 15 | Background hot total |
| bkg_cold_o | output | 15 | Background cold total |
| done_o | output | 1 | One-cycle strobe: all totals are final |

## Verification
The assertions run on every cycle. They check that done never lasts two cycles, that the totals never decrease except through start, that start always leaves the totals at zero, that the totals stay frozen while done is high, and that no pair of totals exceeds its arithmetic bound.

Only the bench scenarios can show the rest. That covers the values of the totals for varied sample patterns, including the equality case and the maximum case. It also covers dropping of early targets, surplus samples, idle cycles and samples that collide with start, and the exact cycle in which done rises.

// File: rtl/hcd_pkg.sv
// Shared types for the hot/cold deviation accumulator.
// Assumes: a single kind bit tells background from target samples.
package hcd_pkg;

    typedef enum logic {
        KIND_BKG = 1'b0,
        KIND_TGT = 1'b1
    } smp_kind_e;

endpackage

// File: rtl/hcd_scale.sv
// Constant multiplier: y = NSAMP * x, built from shifted copies of x.
// Only the set bits of NSAMP produce an adder, so no general multiplier.
// Assumes: OUT_W is wide enough for NSAMP * (2**PIX_W - 1).
module hcd_scale #(
    parameter int PIX_W = 5,
    parameter int NSAMP = 30,
    parameter int OUT_W = 10
) (
    input  logic [PIX_W-1:0] x,
    output logic [OUT_W-1:0] y
);
    localparam int NB = $clog2(NSAMP + 1);

    logic [OUT_W-1:0] part [NB+1];

    // Chain seed: nothing added yet
    assign part[0] = '0;

    for (genvar b = 0; b < NB; b++) begin : g_bit
        if (((NSAMP >> b) & 1) == 1) begin : g_add
            // Add x shifted by this bit position
            assign part[b+1] = part[b] + (OUT_W'(x) << b);
        end else begin : g_skip
            // Bit clear: pass the partial product through
            assign part[b+1] = part[b];
        end
    end

    assign y = part[NB];

endmodule

// File: rtl/hcd_split.sv
// Compares a scaled sample against the background sum.
// Reports whether it is hot, and the size of the difference.
// Equality is treated as cold with zero magnitude.
// Assumes: both operands share one width.
module hcd_split #(
    parameter int W = 10
) (
    input  logic [W-1:0] scaled,
    input  logic [W-1:0] ref_sum,
    output logic         is_hot,
    output logic [W-1:0] mag
);
    // Decide hot/cold and form the non-negative difference
    always_comb begin
        is_hot = (scaled > ref_sum);
        mag    = is_hot ? (scaled - ref_sum) : (ref_sum - scaled);
    end

endmodule

// File: rtl/hcd_pair_acc.sv
// Hot/cold total pair: adds a magnitude into one of two totals.
// Assumes: ACC_W leaves room for NSAMP worst-case magnitudes.
module hcd_pair_acc #(
    parameter int MAG_W = 10,
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             is_hot,
    input  logic [MAG_W-1:0] mag,
    output logic [ACC_W-1:0] hot_tot,
    output logic [ACC_W-1:0] cold_tot
);
    // Accumulate into the total picked by is_hot; clear on reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hot_tot  <= '0;
            cold_tot <= '0;
        end else if (en) begin
            if (is_hot) hot_tot  <= hot_tot  + ACC_W'(mag);
            else        cold_tot <= cold_tot + ACC_W'(mag);
        end
    end

endmodule

// File: rtl/hcd_bkg_store.sv
// Background sample buffer with running sum.
// Writes one sample per wr_en at wr_idx and adds it to the sum.
// Reads the entry at rd_idx without a clock.
// Assumes: wr_idx < NSAMP whenever wr_en is high.
module hcd_bkg_store #(
    parameter int PIX_W = 5,
    parameter int NSAMP = 30,
    parameter int IDX_W = 5,
    parameter int SUM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PIX_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PIX_W-1:0] rd_data,
    output logic [SUM_W-1:0] sum
);
    logic [PIX_W-1:0] mem [NSAMP];

    for (genvar i = 0; i < NSAMP; i++) begin : g_ent
        // Capture one buffer entry when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) mem[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
        end
    end

    // Running sum of the written samples
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= '0;
        else if (wr_en)    sum <= sum + SUM_W'(wr_data);
    end

    // Replay read; out-of-range indices return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSAMP; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = mem[i];
        end
    end

endmodule

// File: rtl/hotcold_dev_accum.sv
// Top level: sequences the background capture, the background replay
// and the target scoring, then strobes done once all 2*NSAMP samples
// have been accumulated.
// Assumes: background samples come before the targets that are to count.
module hotcold_dev_accum #(
    parameter int PIX_W = 5,
    parameter int NSAMP = 30
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start_i,
    input  logic                                       smp_valid_i,
    input  logic                                       smp_is_tgt_i,
    input  logic [PIX_W-1:0]                           smp_i,
    output logic [PIX_W+2*$clog2(NSAMP+1)-1:0]         tgt_hot_o,
    output logic [PIX_W+2*$clog2(NSAMP+1)-1:0]         tgt_cold_o,
    output logic [PIX_W+2*$clog2(NSAMP+1)-1:0]         bkg_hot_o,
    output logic [PIX_W+2*$clog2(NSAMP+1)-1:0]         bkg_cold_o,
    output logic                                       done_o
);
    import hcd_pkg::*;

    localparam int CNT_W = $clog2(NSAMP + 1);
    localparam int IDX_W = $clog2(NSAMP);
    localparam int SCL_W = PIX_W + CNT_W;
    localparam int ACC_W = SCL_W + CNT_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NSAMP);

    logic [CNT_W-1:0] bkg_cnt, tgt_cnt, rep_cnt;
    logic             fin_seen, done_q;
    logic             sum_ready, bkg_take, tgt_take, rep_go, all_in;
    smp_kind_e        kind;
    logic [SCL_W-1:0] ref_sum;
    logic [PIX_W-1:0] rep_smp;
    logic [SCL_W-1:0] tgt_scl, bkg_scl, tgt_mag, bkg_mag;
    logic             tgt_hot, bkg_hot;

    // Decode the kind bit and the per-cycle accept conditions
    always_comb begin
        kind      = smp_kind_e'(smp_is_tgt_i);
        sum_ready = (bkg_cnt == FULL);
        bkg_take  = smp_valid_i && !start_i && kind == KIND_BKG && bkg_cnt < FULL;
        tgt_take  = smp_valid_i && !start_i && kind == KIND_TGT && sum_ready
                    && tgt_cnt < FULL;
        rep_go    = !start_i && sum_ready && rep_cnt < FULL;
        all_in    = (tgt_cnt == FULL) && (rep_cnt == FULL);
    end

    // Sample counters for capture, replay and targets
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            bkg_cnt <= '0;
            tgt_cnt <= '0;
            rep_cnt <= '0;
        end else begin
            if (bkg_take) bkg_cnt <= bkg_cnt + CNT_W'(1);
            if (tgt_take) tgt_cnt <= tgt_cnt + CNT_W'(1);
            if (rep_go)   rep_cnt <= rep_cnt + CNT_W'(1);
        end
    end

    // One-shot done strobe, the cycle after the last accumulation
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            done_q   <= 1'b0;
            fin_seen <= 1'b0;
        end else begin
            done_q <= all_in && !fin_seen;
            if (all_in) fin_seen <= 1'b1;
        end
    end

    hcd_bkg_store #(
        .PIX_W (PIX_W),
        .NSAMP (NSAMP),
        .IDX_W (IDX_W),
        .SUM_W (SCL_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_i),
        .wr_en   (bkg_take),
        .wr_idx  (bkg_cnt[IDX_W-1:0]),
        .wr_data (smp_i),
        .rd_idx  (rep_cnt[IDX_W-1:0]),
        .rd_data (rep_smp),
        .sum     (ref_sum)
    );

    hcd_scale #(.PIX_W(PIX_W), .NSAMP(NSAMP), .OUT_W(SCL_W)) u_scl_tgt (
        .x (smp_i),
        .y (tgt_scl)
    );

    hcd_scale #(.PIX_W(PIX_W), .NSAMP(NSAMP), .OUT_W(SCL_W)) u_scl_bkg (
        .x (rep_smp),
        .y (bkg_scl)
    );

    hcd_split #(.W(SCL_W)) u_split_tgt (
        .scaled  (tgt_scl),
        .ref_sum (ref_sum),
        .is_hot  (tgt_hot),
        .mag     (tgt_mag)
    );

    hcd_split #(.W(SCL_W)) u_split_bkg (
        .scaled  (bkg_scl),
        .ref_sum (ref_sum),
        .is_hot  (bkg_hot),
        .mag     (bkg_mag)
    );

    hcd_pair_acc #(.MAG_W(SCL_W), .ACC_W(ACC_W)) u_acc_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_i),
        .en       (tgt_take),
        .is_hot   (tgt_hot),
        .mag      (tgt_mag),
        .hot_tot  (tgt_hot_o),
        .cold_tot (tgt_cold_o)
    );

    hcd_pair_acc #(.MAG_W(SCL_W), .ACC_W(ACC_W)) u_acc_bkg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_i),
        .en       (rep_go),
        .is_hot   (bkg_hot),
        .mag      (bkg_mag),
        .hot_tot  (bkg_hot_o),
        .cold_tot (bkg_cold_o)
    );

    assign done_o = done_q;

endmodule

// File: rtl/hcd_accum_chk.sv
// Port-level checker for hotcold_dev_accum, bound to every instance.
// Assumes: synchronous active-low reset.
module hcd_accum_chk #(
    parameter int PIX_W = 5,
    parameter int NSAMP = 30,
    parameter int ACC_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [ACC_W-1:0] tgt_hot_o,
    input logic [ACC_W-1:0] tgt_cold_o,
    input logic [ACC_W-1:0] bkg_hot_o,
    input logic [ACC_W-1:0] bkg_cold_o,
    input logic             done_o
);
    localparam int LIMIT = NSAMP * NSAMP * ((1 << PIX_W) - 1);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tgt_hot_o == '0 && tgt_cold_o == '0 && bkg_hot_o == '0
                     && bkg_cold_o == '0 && !done_o));

    // R3
    no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (tgt_hot_o >= $past(tgt_hot_o) && tgt_cold_o >= $past(tgt_cold_o)
                      && bkg_hot_o >= $past(bkg_hot_o) && bkg_cold_o >= $past(bkg_cold_o)));

    // R8
    hold_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(tgt_hot_o) && $stable(tgt_cold_o)
                                  && $stable(bkg_hot_o) && $stable(bkg_cold_o)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tgt_hot_o) + int'(tgt_cold_o) <= LIMIT)
        && (int'(bkg_hot_o) + int'(bkg_cold_o) <= LIMIT));

endmodule

bind hotcold_dev_accum hcd_accum_chk #(
    .PIX_W (PIX_W),
    .NSAMP (NSAMP),
    .ACC_W (ACC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tgt_hot_o  (tgt_hot_o),
    .tgt_cold_o (tgt_cold_o),
    .bkg_hot_o  (bkg_hot_o),
    .bkg_cold_o (bkg_cold_o),
    .done_o     (done_o)
);

// File: tb/hotcold_dev_accum_test.sv
`timescale 1ns/1ps
module hotcold_dev_accum_test;

    localparam int N = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic        smp_is_tgt_i = 1'b0;
    logic [4:0]  smp_i = '0;
    logic [14:0] tgt_hot_o, tgt_cold_o, bkg_hot_o, bkg_cold_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    // Bench-side record of the samples the requirements say are accepted
    int acc_b[N];
    int acc_t[N];
    int nb = 0;
    int nt = 0;

    // Table: background kind/param, target kind/param
    localparam int NV = 7;
    localparam int BK[NV] = '{0, 0, 1, 2, 3, 0, 3};
    localparam int BP[NV] = '{10, 10, 4, 7, 11, 31, 5};
    localparam int TK[NV] = '{0, 0, 3, 1, 2, 0, 3};
    localparam int TP[NV] = '{10, 11, 9, 20, 3, 0, 23};

    hotcold_dev_accum uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .smp_valid_i  (smp_valid_i),
        .smp_is_tgt_i (smp_is_tgt_i),
        .smp_i        (smp_i),
        .tgt_hot_o    (tgt_hot_o),
        .tgt_cold_o   (tgt_cold_o),
        .bkg_hot_o    (bkg_hot_o),
        .bkg_cold_o   (bkg_cold_o),
        .done_o       (done_o)
    );

    always #4 clk = ~clk;

    function automatic int gen(int k, int p, int i);
        case (k)
            0:       return p % 32;
            1:       return (p + i) % 32;
            2:       return (i % 2 == 1) ? p % 32 : 31 - (p % 32);
            default: return (i * p * 7 + 3 * i + p) % 32;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs and update the bench record
    task automatic drive(bit st, bit v, bit k, int d);
        @(negedge clk);
        start_i      = st;
        smp_valid_i  = v;
        smp_is_tgt_i = k;
        smp_i        = 5'(d);
        @(posedge clk);
        if (st) begin
            nb = 0;
            nt = 0;
        end else if (v && !k && nb < N) begin
            acc_b[nb] = d;
            nb++;
        end else if (v && k && nb == N && nt < N) begin
            acc_t[nt] = d;
            nt++;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        start_i     = 1'b0;
        smp_valid_i = 1'b0;
    endtask

    // Compare the four totals with values computed from the record
    task automatic check_totals(string req);
        int s = 0;
        int th = 0, tc = 0, bh = 0, bc = 0;
        for (int i = 0; i < nb; i++) s += acc_b[i];
        for (int i = 0; i < nb; i++) begin
            if (30 * acc_b[i] > s) bh += 30 * acc_b[i] - s;
            else                   bc += s - 30 * acc_b[i];
        end
        for (int i = 0; i < nt; i++) begin
            if (30 * acc_t[i] > s) th += 30 * acc_t[i] - s;
            else                   tc += s - 30 * acc_t[i];
        end
        check({req, " tgt_hot"},  int'(tgt_hot_o),  th);
        check({req, " tgt_cold"}, int'(tgt_cold_o), tc);
        check({req, " bkg_hot"},  int'(bkg_hot_o),  bh);
        check({req, " bkg_cold"}, int'(bkg_cold_o), bc);
    endtask

    // Wait at negedges for done, then check the totals and the pulse width
    task automatic wait_done(string req);
        bit seen = 0;
        for (int c = 0; c < 100 && !seen; c++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        check({req, " done seen"}, int'(seen), 1);
        check_totals(req);
        @(negedge clk);
        check({req, " done one cycle"}, int'(done_o), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 tgt_hot",  int'(tgt_hot_o), 0);
        check("R1 tgt_cold", int'(tgt_cold_o), 0);
        check("R1 bkg_hot",  int'(bkg_hot_o), 0);
        check("R1 bkg_cold", int'(bkg_cold_o), 0);
        check("R1 done",     int'(done_o), 0);

        // R1: a frame straight after reset, with no start pulse
        for (int i = 0; i < N; i++) drive(0, 1, 0, gen(1, 2, i));
        for (int i = 0; i < N; i++) drive(0, 1, 1, gen(3, 4, i));
        idle();
        wait_done("R1 armed");

        // Table walk: R3 R4 R5 R8 R11, with exact done timing
        for (int v = 0; v < NV; v++) begin
            drive(1, 0, 0, 0);
            for (int i = 0; i < N; i++) drive(0, 1, 0, gen(BK[v], BP[v], i));
            for (int i = 0; i < N; i++) drive(0, 1, 1, gen(TK[v], TP[v], i));
            idle();
            check("R8 not early", int'(done_o), 0);
            @(negedge clk);
            check("R8 done rises", int'(done_o), 1);
            check_totals("R3 R4 R5 R11");
            @(negedge clk);
            check("R8 pulse ends", int'(done_o), 0);
        end

        // R5: equality adds nothing (bkg all 10 so SUM=300, tgt 10)
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) drive(0, 1, 0, 10);
        for (int i = 0; i < N; i++) drive(0, 1, 1, 10);
        idle();
        wait_done("R5");
        check("R5 all zero", int'(tgt_hot_o) + int'(tgt_cold_o)
                             + int'(bkg_hot_o) + int'(bkg_cold_o), 0);

        // R11: maximum target cold total
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) drive(0, 1, 0, 31);
        for (int i = 0; i < N; i++) drive(0, 1, 1, 0);
        idle();
        wait_done("R11");
        check("R11 max cold", int'(tgt_cold_o), 27900);

        // R6: an early target in the middle of the background stream is dropped
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) begin
            drive(0, 1, 0, gen(3, 9, i));
            if (i == 4) drive(0, 1, 1, 31);
        end
        for (int i = 0; i < N; i++) drive(0, 1, 1, gen(0, 3, i));
        idle();
        wait_done("R6");

        // R7: surplus background and target samples are ignored
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) drive(0, 1, 0, gen(1, 6, i));
        drive(0, 1, 0, 31);
        for (int i = 0; i < N; i++) drive(0, 1, 1, gen(2, 12, i));
        idle();
        wait_done("R7");
        drive(0, 1, 1, 31);
        drive(0, 1, 0, 0);
        drive(0, 1, 1, 0);
        idle();
        repeat (3) begin
            check("R7 no second done", int'(done_o), 0);
            @(negedge clk);
        end
        check_totals("R7 unchanged");

        // R9: valid-low cycles with junk data between samples
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) begin
            drive(0, 1, 0, gen(3, 2, i));
            drive(0, 0, 1, 31);
        end
        for (int i = 0; i < N; i++) begin
            drive(0, 0, 0, 0);
            drive(0, 1, 1, gen(1, 17, i));
        end
        idle();
        wait_done("R9");

        // R2: start in mid-frame clears everything
        drive(1, 0, 0, 0);
        for (int i = 0; i < N; i++) drive(0, 1, 0, gen(2, 1, i));
        for (int i = 0; i < 10; i++) drive(0, 1, 1, 30);
        drive(1, 0, 0, 0);
        @(negedge clk);
        check("R2 cleared", int'(tgt_hot_o) + int'(tgt_cold_o)
                            + int'(bkg_hot_o) + int'(bkg_cold_o), 0);
        check("R2 done low", int'(done_o), 0);

        // R10: start colliding with a valid sample drops that sample
        drive(1, 1, 0, 31);
        for (int i = 0; i < N; i++) drive(0, 1, 0, gen(1, 3, i));
        for (int i = 0; i < N; i++) drive(0, 1, 1, gen(3, 8, i));
        idle();
        wait_done("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule